// File: doc/BRIEF.md
# Dual-Slope Conversion Phase Sequencer

This block sequences a dual-slope analog-to-digital conversion. A counter made of BCD decades runs without stopping, one step per count clock. Fixed counter positions mark the phases. Input integration starts at a fixed position and lasts until the counter rolls over to zero. The rollover samples the comparator, and that sample picks one of two reference strobes, so the reference drives the integrator against the input. The reference phase ends when the comparator flips. At that point the counter value is latched as the BCD result and the auto-zero phase begins. If the comparator never flips, a hard count limit forces auto-zero, and the result is latched as the limit value with an overrange flag.

The integrator, comparator, switches and reference source are outside the block. The sequencer only drives the four phase strobes and reads the single comparator bit. The number of decades and the leading digits of the integration start and the overrange limit are parameters. The defaults give four decades, a start at 7000 and a limit at 6000.

Top module: `dslope_seq`

## Requirements
- R1: The counter has NDEC BCD decades and is cleared to zero by reset. It advances by one on every clock and rolls over from 10^NDEC−1 to zero. Reference integration always begins in the clock where the counter reads zero, so successive reference phases start exactly 10^NDEC clocks apart.
- R2: During reset and after it, the outputs are ph_az=1, ph_int=0, ph_ref_pos=0, ph_ref_neg=0, res_bcd=0, pol=0, ovr=0 and res_ld=0. Auto-zero stays active until the counter first reaches the start position.
- R3: ph_int is high in every clock in which the counter reads from START_DIGIT·10^(NDEC−1) up to 10^NDEC−1. This is a fixed (10−START_DIGIT)·10^(NDEC−1) clocks.
- R4: At the clock edge where the counter rolls over to zero, the comparator level is captured. A captured 1 makes ph_ref_neg high and a captured 0 makes ph_ref_pos high. The strobe holds for the whole reference phase.
- R5: During reference integration, the first clock edge where cmp_in differs from the captured level ends the phase. The counter value at that edge becomes res_bcd, with nibble 0 holding the units, and ovr becomes 0. ph_az is high from the next clock.
- R6: If the comparator has not changed by the time the counter reaches LIMIT_DIGIT·10^(NDEC−1), auto-zero starts in the clock where the counter shows that value. res_bcd then equals that value and ovr becomes 1.
- R7: res_ld is a one-clock pulse in the first clock of each auto-zero phase that follows a reference phase. res_bcd, pol and ovr change only in that clock and hold until the next pulse.
- R8: pol is latched with each result and equals the comparator level captured at the rollover that opened that conversion.
- R9: cmp_in has no effect on any output outside reference integration. This covers input integration, except for the rollover edge, and auto-zero.
- R10: Exactly one of ph_int, ph_ref_pos, ph_ref_neg and ph_az is high in every clock. Auto-zero lasts until the counter reaches the start position again.
- R11: A comparator change sampled while the counter reads LIMIT−1 is in range. The result is LIMIT−1 and ovr is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_in | input | 1 | Comparator output from the integrator |
| ph_int | output | 1 | Input-integration strobe |
| ph_ref_pos | output | 1 | Reference strobe selected by a captured 0 |
| ph_ref_neg | output | 1 | Reference strobe selected by a captured 1 |
| ph_az | output | 1 | Auto-zero strobe |
| pol | output | 1 | Polarity latched with the result |
| res_bcd | output | 4·NDEC | Latched BCD result, nibble 0 = units |
| ovr | output | 1 | Overrange flag latched with the result |
| res_ld | output | 1 | One-clock pulse when a result is latched |

## Verification
Every output is a register. A strobe, result or flag is therefore due in the clock that directly follows the edge that caused it. When the comparator flips while the counter shows X, the latched result X and the res_ld pulse appear one clock later, which is also when the counter shows X+1. The forced overrange result appears in the clock where the counter reads the limit. The bench counts clock edges from reset release and derives the counter position arithmetically. It drives cmp_in and compares every output at the falling edge, half a clock after the edge that updated them. It sweeps the comparator delay from 0 past the limit, for both captured levels, with a two-decade configuration. It also toggles cmp_in freely during input integration and auto-zero.

// File: rtl/dsq_pkg.sv
package dsq_pkg;
   localparam int DIGIT_W = 4;

   typedef enum logic [1:0] {
      PH_AZ    = 2'd0,
      PH_INT   = 2'd1,
      PH_DEINT = 2'd2
   } phase_t;
endpackage

// File: rtl/dsq_decade.sv
module dsq_decade
   import dsq_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cin,
   output logic [DIGIT_W-1:0] q,
   output logic [DIGIT_W-1:0] q_nxt,
   output logic               cout
);
   localparam logic [DIGIT_W-1:0] NINE = DIGIT_W'(9);

   always_comb begin
      cout  = cin && (q == NINE);
      q_nxt = q;
      if (cin) q_nxt = (q == NINE) ? '0 : q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else        q <= q_nxt;
   end

   // R1: a decade never leaves the BCD range
   p_digit_bcd_r1: assert property (@(posedge clk) disable iff (!rst_n) q <= NINE);
endmodule

// File: rtl/dsq_counter.sv
module dsq_counter
   import dsq_pkg::*;
#(
   parameter int NDEC = 4,
   localparam int W = NDEC * DIGIT_W
)(
   input  logic         clk,
   input  logic         rst_n,
   output logic [W-1:0] cnt,
   output logic [W-1:0] cnt_nxt,
   output logic         wrap
);
   logic [NDEC:0] carry;
   assign carry[0] = 1'b1;

   for (genvar i = 0; i < NDEC; i++) begin : g_dec
      dsq_decade u_dec (
         .clk   (clk),
         .rst_n (rst_n),
         .cin   (carry[i]),
         .q     (cnt[i*DIGIT_W +: DIGIT_W]),
         .q_nxt (cnt_nxt[i*DIGIT_W +: DIGIT_W]),
         .cout  (carry[i+1])
      );
   end

   assign wrap = carry[NDEC];

   // R1: a full carry out always leaves the counter at zero
   p_wrap_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> (cnt == '0));
endmodule

// File: rtl/dsq_phase.sv
module dsq_phase
   import dsq_pkg::*;
#(
   parameter int NDEC = 4,
   parameter int START_DIGIT = 7,
   parameter int LIMIT_DIGIT = 6,
   localparam int W = NDEC * DIGIT_W,
   localparam logic [W-1:0] START_BCD = W'(START_DIGIT) << (W - DIGIT_W),
   localparam logic [W-1:0] LIMIT_BCD = W'(LIMIT_DIGIT) << (W - DIGIT_W)
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] cnt,
   input  logic [W-1:0] cnt_nxt,
   input  logic         wrap,
   input  logic         cmp_in,
   output phase_t       phase,
   output logic         cap,
   output logic         stop,
   output logic         forced
);
   phase_t phase_nxt;

   always_comb begin
      phase_nxt = phase;
      stop      = 1'b0;
      forced    = 1'b0;
      case (phase)
         PH_AZ:    if (cnt_nxt == START_BCD) phase_nxt = PH_INT;
         PH_INT:   if (wrap) phase_nxt = PH_DEINT;
         PH_DEINT: begin
            if (cmp_in != cap) begin
               stop      = 1'b1;
               phase_nxt = PH_AZ;
            end else if (cnt_nxt == LIMIT_BCD) begin
               stop      = 1'b1;
               forced    = 1'b1;
               phase_nxt = PH_AZ;
            end
         end
         default:  phase_nxt = PH_AZ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase <= PH_AZ;
         cap   <= 1'b0;
      end else begin
         phase <= phase_nxt;
         if (phase == PH_INT && wrap) cap <= cmp_in;
      end
   end

   // R3: input integration is entered only at the start position
   p_int_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_INT && $past(phase) != PH_INT) |-> (cnt == START_BCD));
   // R4: reference integration is entered only at zero, straight from input integration
   p_deint_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_DEINT && $past(phase) != PH_DEINT) |-> (cnt == '0 && $past(phase) == PH_INT));
   // R4: captured level is frozen throughout reference integration
   p_cap_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_DEINT && $past(phase) == PH_DEINT) |-> $stable(cap));
   // R6: reference integration never reaches the limit count
   p_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_DEINT) |-> (cnt < LIMIT_BCD));
endmodule

// File: rtl/dsq_result.sv
module dsq_result
   import dsq_pkg::*;
#(
   parameter int NDEC = 4,
   parameter int LIMIT_DIGIT = 6,
   localparam int W = NDEC * DIGIT_W,
   localparam logic [W-1:0] LIMIT_BCD = W'(LIMIT_DIGIT) << (W - DIGIT_W)
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         forced,
   input  logic         cap,
   input  logic [W-1:0] cnt,
   output logic [W-1:0] res,
   output logic         pol,
   output logic         ovr,
   output logic         ld
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res <= '0;
         pol <= 1'b0;
         ovr <= 1'b0;
         ld  <= 1'b0;
      end else begin
         ld <= load;
         if (load) begin
            res <= forced ? LIMIT_BCD : cnt;
            pol <= cap;
            ovr <= forced;
         end
      end
   end

   // R7: result, polarity and flag move only with the load pulse
   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !ld |-> ($stable(res) && $stable(pol) && $stable(ovr)));
   // R6: an overrange result always carries the limit value
   p_ovr_value_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ovr |-> (res == LIMIT_BCD));
endmodule

// File: rtl/dslope_seq.sv
module dslope_seq
   import dsq_pkg::*;
#(
   parameter int NDEC = 4,
   parameter int START_DIGIT = 7,
   parameter int LIMIT_DIGIT = 6,
   localparam int W = NDEC * DIGIT_W
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cmp_in,
   output logic         ph_int,
   output logic         ph_ref_pos,
   output logic         ph_ref_neg,
   output logic         ph_az,
   output logic         pol,
   output logic [W-1:0] res_bcd,
   output logic         ovr,
   output logic         res_ld
);
   if (NDEC < 1 || NDEC > 8) begin : g_bad_ndec
      $error("dslope_seq: NDEC must lie in 1..8");
   end
   if (START_DIGIT < 1 || START_DIGIT > 9) begin : g_bad_start
      $error("dslope_seq: START_DIGIT must lie in 1..9");
   end
   if (LIMIT_DIGIT < 1 || LIMIT_DIGIT >= START_DIGIT) begin : g_bad_limit
      $error("dslope_seq: LIMIT_DIGIT must lie in 1..START_DIGIT-1");
   end

   logic [W-1:0] cnt, cnt_nxt;
   logic         wrap, cap, stop, forced;
   phase_t       phase;

   dsq_counter #(.NDEC(NDEC)) u_cnt (
      .clk (clk), .rst_n (rst_n), .cnt (cnt), .cnt_nxt (cnt_nxt), .wrap (wrap)
   );

   dsq_phase #(.NDEC(NDEC), .START_DIGIT(START_DIGIT), .LIMIT_DIGIT(LIMIT_DIGIT)) u_phase (
      .clk (clk), .rst_n (rst_n), .cnt (cnt), .cnt_nxt (cnt_nxt), .wrap (wrap),
      .cmp_in (cmp_in), .phase (phase), .cap (cap), .stop (stop), .forced (forced)
   );

   dsq_result #(.NDEC(NDEC), .LIMIT_DIGIT(LIMIT_DIGIT)) u_res (
      .clk (clk), .rst_n (rst_n), .load (stop), .forced (forced), .cap (cap),
      .cnt (cnt), .res (res_bcd), .pol (pol), .ovr (ovr), .ld (res_ld)
   );

   assign ph_int     = (phase == PH_INT);
   assign ph_ref_pos = (phase == PH_DEINT) && !cap;
   assign ph_ref_neg = (phase == PH_DEINT) &&  cap;
   assign ph_az      = (phase == PH_AZ);

   // R10: exactly one phase strobe at a time
   p_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({ph_int, ph_ref_pos, ph_ref_neg, ph_az}) == 1);
   // R7: the load pulse coincides with the first auto-zero clock after reference integration
   p_ld_az_r7: assert property (@(posedge clk) disable iff (!rst_n)
      res_ld |-> (ph_az && ($past(ph_ref_pos) || $past(ph_ref_neg))));
   // R8: polarity latched equals the reference strobe that just ended
   p_pol_r8: assert property (@(posedge clk) disable iff (!rst_n)
      res_ld |-> (pol == $past(ph_ref_neg)));
endmodule

// File: tb/sim_dslope_seq.sv
`timescale 1ns/1ps
module sim_dslope_seq;
   localparam int ND    = 2;
   localparam int SD    = 7;
   localparam int LD    = 6;
   localparam int M     = 10 ** ND;
   localparam int START = SD * (10 ** (ND - 1));
   localparam int LIMIT = LD * (10 ** (ND - 1));
   localparam int KSPAN = LIMIT + 4;
   localparam int NCONV = 2 * KSPAN;
   localparam int W     = 4 * ND;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmp_in = 1'b0;
   logic ph_int, ph_ref_pos, ph_ref_neg, ph_az, pol, ovr, res_ld;
   logic [W-1:0] res_bcd;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   dslope_seq #(.NDEC(ND), .START_DIGIT(SD), .LIMIT_DIGIT(LD)) u0 (
      .clk (clk), .rst_n (rst_n), .cmp_in (cmp_in),
      .ph_int (ph_int), .ph_ref_pos (ph_ref_pos), .ph_ref_neg (ph_ref_neg), .ph_az (ph_az),
      .pol (pol), .res_bcd (res_bcd), .ovr (ovr), .res_ld (res_ld)
   );

   function automatic int kf(int j);
      return j % KSPAN;
   endfunction

   function automatic bit sf(int j);
      return bit'(((j / KSPAN) % 2) ^ (j % 2));
   endfunction

   function automatic logic [W-1:0] to_bcd(int v);
      logic [W-1:0] r = '0;
      int x = v;
      for (int d = 0; d < ND; d++) begin
         r[d*4 +: 4] = 4'(x % 10);
         x = x / 10;
      end
      return r;
   endfunction

   task automatic chk(bit ok, string tag, string what, int act, int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   initial begin : main
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R2: reset values while reset is held
      chk({ph_int, ph_ref_pos, ph_ref_neg, ph_az} == 4'b0001, "R2", "strobes in reset",
          int'({ph_int, ph_ref_pos, ph_ref_neg, ph_az}), 1);
      chk(res_bcd == '0 && pol == 1'b0 && ovr == 1'b0 && res_ld == 1'b0, "R2", "result in reset",
          int'({res_bcd, pol, ovr, res_ld}), 0);
      rst_n = 1'b1;
      for (int t = 0; t <= M * NCONV + LIMIT + 2; t++) begin
         int c, jw, e, jj;
         bit s;
         logic [3:0] exp_ph, act_ph;
         logic [W-1:0] exp_res;
         bit exp_pol, exp_ovr, exp_ld;
         string tag;
         if (t > 0) begin
            @(posedge clk);
            @(negedge clk);
         end
         c  = t % M;
         jw = t / M - 1;
         exp_ld = 1'b0;
         e = 0;
         if (jw >= 0) e = (kf(jw) < LIMIT) ? kf(jw) + 1 : LIMIT;
         // expected strobes {int, ref_pos, ref_neg, az}
         if (c >= START) begin
            exp_ph = 4'b1000;
            tag = "R3";
         end else if (jw < 0) begin
            exp_ph = 4'b0001;
            tag = "R2";
         end else if (c < e) begin
            exp_ph = sf(jw) ? 4'b0010 : 4'b0100;
            tag = (c == 0) ? "R1" : "R4";
         end else begin
            exp_ph = 4'b0001;
            tag = "R9";
            exp_ld = (c == e);
         end
         act_ph = {ph_int, ph_ref_pos, ph_ref_neg, ph_az};
         chk(act_ph == exp_ph, tag, "phase strobes", int'(act_ph), int'(exp_ph));
         // R10: never more or fewer than one strobe
         chk($countones(act_ph) == 1, "R10", "strobe count", $countones(act_ph), 1);
         // expected latched result from the latest finished conversion
         jj = (jw >= 0 && c >= e && c < START) ? jw : jw - 1;
         if (c >= START) jj = jw;
         if (jj < 0) begin
            exp_res = '0; exp_pol = 1'b0; exp_ovr = 1'b0;
         end else begin
            exp_res = to_bcd(kf(jj) < LIMIT ? kf(jj) : LIMIT);
            exp_pol = sf(jj);
            exp_ovr = (kf(jj) >= LIMIT);
         end
         if (exp_ld) tag = (kf(jw) < LIMIT - 1) ? "R5" : (kf(jw) == LIMIT - 1) ? "R11" : "R6";
         else        tag = "R7";
         chk(res_bcd == exp_res, tag, "res_bcd", int'(res_bcd), int'(exp_res));
         chk(ovr == exp_ovr, tag, "ovr", int'(ovr), int'(exp_ovr));
         chk(res_ld == exp_ld, "R7", "res_ld", int'(res_ld), int'(exp_ld));
         chk(pol == exp_pol, "R8", "pol", int'(pol), int'(exp_pol));
         // comparator stimulus, sampled at the next rising edge
         if (c >= START) begin
            s = sf(t / M);
            // R9: toggling during input integration must not matter
            cmp_in = (c == M - 1) ? s : ((c % 3 == 0) ? ~s : s);
         end else if (jw >= 0 && c < LIMIT) begin
            s = sf(jw);
            cmp_in = (c >= kf(jw)) ? ~s : s;
         end else begin
            // R9: toggling during auto-zero must not matter
            cmp_in = c[0];
         end
      end
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 200000, M * NCONV);
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule